// File: doc/BRIEF.md
# Cyclic Audio DMA Channel

This block is one DMA channel that moves 32-bit words around a ring buffer without stopping. In the memory-to-device direction it reads words from memory and hands them to an audio FIFO. In the device-to-memory direction it takes words from the FIFO and writes them to memory. Software sets the period length in bytes, the number of periods in the ring (1 to 8), the burst length, the direction and the buffer base. It then writes the command register. From then on the channel walks the ring on its own. At the end of each period it raises an interrupt, bumps a wrapping period counter and reloads its per-period byte counter.

Software can read the live remaining-byte count and the period counter at any time, so it can work out the exact position in the ring while the transfer runs. A pause bit stops the channel at the next burst boundary, and clearing the bit lets it continue from the same position. Clearing the command bit stops the channel at the next burst boundary.

The memory side is a single-word request/grant port. The read data is valid in the grant cycle. The device side has two ready/valid streams, each with a fill-level input that the flow control uses.

Top module: `cyc_audio_dma`

## Requirements
- R1: After reset, status (0x0C) reads 0, the remaining count (0x30) reads 0, `irq` is 0 and no handshake signal is asserted. Writing 1 to command bit 0 (0x00), with a valid direction and a non-zero length, sets status bit 0 (enabled). The transfer then starts at the buffer base: source base (0x34) when sending to the device, target base (0x3C) when receiving from it.
- R2: A start is refused if control bits [15:12] (0x24) are neither 4 (memory to device) nor 2 (device to memory), or if the period length is zero. A refused start leaves command and status reading 0.
- R3: Memory to device: each word read at the current pointer is delivered on `tx_data` in order. The pointer then advances by 4.
- R4: Device to memory: each word accepted from `rx_data` is written to memory in arrival order at a pointer that advances by 4.
- R5: The ring holds P periods. P is config (0x28) bits [30:28]+1 when sending and bits [26:24]+1 when receiving. After the last word of period P the pointer returns to the base.
- R6: A burst is B = config bits [23:20]+1 words. With control bit 1 (flow control) set, a burst starts only when `tx_room` >= B (sending) or `rx_level` >= B (receiving). A burst also ends early at a period end. Only one of `mem_req`, `tx_valid`, `rx_ready` is high at a time.
- R7: Each period end sets interrupt status bit 0 (0x10), which drives `irq`. Writing 1 in bit 0 of the clear register (0x1C) clears it. A period end in the same cycle as a clear leaves the bit set.
- R8: The period length register (0x44) keeps only the bits in mask 0x3ffffffc. The remaining count (0x30) falls by 4 per word and reloads to the period length at each period end.
- R9: The period counter (0x54, low CNT_W bits) is zeroed at start and goes up by one per completed period, modulo 2^CNT_W.
- R10: Setting control bit 0 pauses the channel at the next burst boundary. Status bit 1 then reads 1 and no handshake is asserted. Clearing control bit 0 resumes the transfer at the next word in sequence.
- R11: Writing 0 to the command register stops the channel after the current burst. Status bit 0 then falls and no further handshakes occur.
- R12: While the channel is enabled, writes to any register other than command, control and interrupt clear are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Period-done interrupt |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory grant; completes the word |
| mem_rdata | input | 32 | Memory read data, valid with grant |
| tx_valid | output | 1 | Word offered to device FIFO |
| tx_data | output | 32 | Word to device FIFO |
| tx_ready | input | 1 | Device FIFO accepts word |
| tx_room | input | LVL_W | Free entries in device FIFO |
| rx_valid | input | 1 | Device FIFO offers word |
| rx_data | input | 32 | Word from device FIFO |
| rx_ready | output | 1 | Channel accepts word |
| rx_level | input | LVL_W | Filled entries in device FIFO |

## Verification
A period end can fall in the same cycle as a software write to the interrupt clear register. When that happens the set has to win, or a period is lost. The bench holds the clear write asserted on every cycle while single-word periods stream. Under that condition `irq` rises once per period and lasts one cycle each time. The bench counts the rising edges of `irq` and expects one edge for every completed period, as counted at the device port.

// File: rtl/cad_pkg.sv
package cad_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_CMD    = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_ISTAT  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_ICLR   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_CFG    = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_FIFO   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_REMAIN = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_SRC    = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_DST    = 8'h3C;
  localparam logic [ADDR_W-1:0] OFF_PLEN   = 8'h44;
  localparam logic [ADDR_W-1:0] OFF_WRAP   = 8'h54;

  localparam logic [3:0] DIR_TO_MEM = 4'd2;
  localparam logic [3:0] DIR_TO_DEV = 4'd4;
  localparam logic [WORD_W-1:0] PLEN_MASK = 32'h3fff_fffc;

  typedef enum logic [2:0] {EN_IDLE, EN_GATE, EN_MEM, EN_DEV, EN_HOLD} eng_state_e;

  // burst length in words from the minus-one field
  function automatic logic [4:0] burst_words(input logic [WORD_W-1:0] cfg);
    return 5'(cfg[23:20]) + 5'd1;
  endfunction

  // periods in the ring; field depends on the direction
  function automatic logic [3:0] ring_periods(input logic [WORD_W-1:0] cfg, input logic to_dev);
    return to_dev ? 4'(cfg[30:28]) + 4'd1 : 4'(cfg[26:24]) + 4'd1;
  endfunction

  function automatic logic dir_valid(input logic [WORD_W-1:0] ctrl);
    return (ctrl[15:12] == DIR_TO_MEM) || (ctrl[15:12] == DIR_TO_DEV);
  endfunction

  function automatic logic [WORD_W-1:0] ptr_after(input logic [WORD_W-1:0] ptr,
                                                  input logic [WORD_W-1:0] base,
                                                  input logic ring_end);
    return ring_end ? base : ptr + 32'd4;
  endfunction
endpackage

// File: rtl/cad_gate.sv
module cad_gate #(
  parameter int LVL_W = 6
) (
  input  logic             flow_en,
  input  logic             to_dev,
  input  logic [LVL_W-1:0] room,
  input  logic [LVL_W-1:0] level,
  input  logic [4:0]       burst,
  output logic             open
);
  localparam int CW = (LVL_W > 5) ? LVL_W : 5;
  logic [CW-1:0] need, have;
  always_comb begin
    need = CW'(burst);
    have = to_dev ? CW'(room) : CW'(level);
    open = !flow_en || (have >= need);
  end
endmodule

// File: rtl/cad_regs.sv
module cad_regs
  import cad_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic              en,
  input  logic              paused,
  input  logic              done_evt,
  input  logic [WORD_W-1:0] remain,
  input  logic [CNT_W-1:0]  wrap,
  output logic              cmd_q,
  output logic [WORD_W-1:0] ctrl_q,
  output logic [WORD_W-1:0] cfg_q,
  output logic [WORD_W-1:0] src_q,
  output logic [WORD_W-1:0] dst_q,
  output logic [WORD_W-1:0] plen_q,
  output logic              istat_q
);
  logic [WORD_W-1:0] fifo_q;
  logic start_ok, cfg_wr_ok;

  assign start_ok  = dir_valid(ctrl_q) && (plen_q != '0);
  assign cfg_wr_ok = wr && !en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= 1'b0; ctrl_q <= '0; cfg_q <= '0; fifo_q <= '0;
      src_q <= '0; dst_q <= '0; plen_q <= '0; istat_q <= 1'b0;
    end else begin
      if (wr && addr == OFF_CMD)  cmd_q  <= wdata[0] & (en | start_ok);
      if (wr && addr == OFF_CTRL) ctrl_q <= wdata;
      if (cfg_wr_ok) begin
        case (addr)
          OFF_CFG:  cfg_q  <= wdata;
          OFF_FIFO: fifo_q <= wdata;
          OFF_SRC:  src_q  <= wdata;
          OFF_DST:  dst_q  <= wdata;
          OFF_PLEN: plen_q <= wdata & PLEN_MASK;
          default: ;
        endcase
      end
      if (done_evt) istat_q <= 1'b1;
      else if (wr && addr == OFF_ICLR && wdata[0]) istat_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      OFF_CMD:    rdata = {31'b0, cmd_q};
      OFF_STAT:   rdata = {30'b0, paused, en};
      OFF_ISTAT:  rdata = {31'b0, istat_q};
      OFF_CTRL:   rdata = ctrl_q;
      OFF_CFG:    rdata = cfg_q;
      OFF_FIFO:   rdata = fifo_q;
      OFF_REMAIN: rdata = remain;
      OFF_SRC:    rdata = src_q;
      OFF_DST:    rdata = dst_q;
      OFF_PLEN:   rdata = plen_q;
      OFF_WRAP:   rdata = WORD_W'(wrap);
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/cad_engine.sv
module cad_engine
  import cad_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd,
  input  logic [WORD_W-1:0] ctrl,
  input  logic [WORD_W-1:0] cfg,
  input  logic [WORD_W-1:0] src,
  input  logic [WORD_W-1:0] dst,
  input  logic [WORD_W-1:0] plen,
  input  logic              gate_ok,
  input  logic              mem_gnt,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_data,
  output logic              to_dev,
  output logic [4:0]        blen,
  output logic              en,
  output logic              paused,
  output logic              word_done,
  output logic              done_evt,
  output logic [WORD_W-1:0] remain,
  output logic [CNT_W-1:0]  wrap,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              tx_valid,
  output logic [WORD_W-1:0] tx_data,
  output logic              rx_ready
);
  eng_state_e state, after_word;
  logic [WORD_W-1:0] ptr, remain_q, hold_q, base;
  logic [2:0] idx;
  logic [4:0] bcnt;
  logic [3:0] nper;
  logic to_dev_q, pause_req, period_last, ring_last, burst_last;

  assign to_dev      = to_dev_q;
  assign pause_req   = ctrl[0];
  assign base        = to_dev_q ? src : dst;
  assign blen        = burst_words(cfg);
  assign nper        = ring_periods(cfg, to_dev_q);
  assign period_last = (remain_q == 32'd4);
  assign ring_last   = ({1'b0, idx} == nper - 4'd1);
  assign burst_last  = (bcnt + 5'd1 == blen);
  assign word_done   = (state == EN_DEV && to_dev_q && tx_ready) ||
                       (state == EN_MEM && !to_dev_q && mem_gnt);
  assign done_evt    = word_done && period_last;
  assign after_word  = (burst_last || period_last) ? EN_GATE : (to_dev_q ? EN_MEM : EN_DEV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= EN_IDLE; ptr <= '0; remain_q <= '0; hold_q <= '0;
      idx <= '0; bcnt <= '0; wrap <= '0; to_dev_q <= 1'b0;
    end else begin
      case (state)
        EN_IDLE: if (cmd) begin
          to_dev_q <= (ctrl[15:12] == DIR_TO_DEV);
          ptr      <= (ctrl[15:12] == DIR_TO_DEV) ? src : dst;
          remain_q <= plen;
          idx      <= '0;
          wrap     <= '0;
          state    <= EN_GATE;
        end
        EN_GATE: begin
          if (!cmd) state <= EN_IDLE;
          else if (pause_req) state <= EN_HOLD;
          else if (gate_ok) begin
            bcnt  <= '0;
            state <= to_dev_q ? EN_MEM : EN_DEV;
          end
        end
        EN_MEM: if (mem_gnt) begin
          if (to_dev_q) begin
            hold_q <= mem_rdata;
            state  <= EN_DEV;
          end else state <= after_word;
        end
        EN_DEV: begin
          if (to_dev_q) begin
            if (tx_ready) state <= after_word;
          end else if (rx_valid) begin
            hold_q <= rx_data;
            state  <= EN_MEM;
          end
        end
        EN_HOLD: begin
          if (!cmd) state <= EN_IDLE;
          else if (!pause_req) state <= EN_GATE;
        end
        default: state <= EN_IDLE;
      endcase
      if (word_done) begin
        ptr      <= ptr_after(ptr, base, period_last && ring_last);
        remain_q <= period_last ? plen : remain_q - 32'd4;
        bcnt     <= bcnt + 5'd1;
        if (period_last) begin
          idx  <= ring_last ? 3'd0 : idx + 3'd1;
          wrap <= wrap + 1'b1;
        end
      end
    end
  end

  assign en        = (state != EN_IDLE);
  assign paused    = (state == EN_HOLD);
  assign remain    = remain_q;
  assign mem_req   = (state == EN_MEM);
  assign mem_we    = !to_dev_q;
  assign mem_addr  = ptr;
  assign mem_wdata = hold_q;
  assign tx_valid  = (state == EN_DEV) && to_dev_q;
  assign tx_data   = hold_q;
  assign rx_ready  = (state == EN_DEV) && !to_dev_q;
endmodule

// File: rtl/cyc_audio_dma.sv
module cyc_audio_dma
  import cad_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LVL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tx_valid,
  output logic [WORD_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic [LVL_W-1:0]  tx_room,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic [LVL_W-1:0]  rx_level
);
  logic cmd_q, istat_q, eng_en, eng_paused, word_done, done_evt, to_dev, gate_ok;
  logic [WORD_W-1:0] ctrl_q, cfg_q, src_q, dst_q, plen_q, remain;
  logic [CNT_W-1:0] wrap;
  logic [4:0] blen;

  cad_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .en(eng_en), .paused(eng_paused), .done_evt(done_evt),
    .remain(remain), .wrap(wrap), .cmd_q(cmd_q), .ctrl_q(ctrl_q), .cfg_q(cfg_q),
    .src_q(src_q), .dst_q(dst_q), .plen_q(plen_q), .istat_q(istat_q)
  );

  cad_gate #(.LVL_W(LVL_W)) u_gate (
    .flow_en(ctrl_q[1]), .to_dev(to_dev), .room(tx_room), .level(rx_level),
    .burst(blen), .open(gate_ok)
  );

  cad_engine #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_q), .ctrl(ctrl_q), .cfg(cfg_q),
    .src(src_q), .dst(dst_q), .plen(plen_q), .gate_ok(gate_ok),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .to_dev(to_dev), .blen(blen),
    .en(eng_en), .paused(eng_paused), .word_done(word_done), .done_evt(done_evt),
    .remain(remain), .wrap(wrap), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .rx_ready(rx_ready)
  );

  assign irq = istat_q;
endmodule

// File: rtl/cad_checker.sv
module cad_checker #(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              paused,
  input logic              done_evt,
  input logic              irq,
  input logic [31:0]       remain,
  input logic [31:0]       plen,
  input logic [31:0]       src,
  input logic [CNT_W-1:0]  wrap,
  input logic              mem_req,
  input logic              tx_valid,
  input logic              rx_ready
);
  a_r10_quiet_when_paused: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !(mem_req || tx_valid || rx_ready));

  a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !(mem_req || tx_valid || rx_ready));

  a_r6_one_side_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, tx_valid, rx_ready}));

  a_r7_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> irq);

  a_r9_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (wrap == CNT_W'($past(wrap) + 1'b1)));

  a_r8_remain_reload: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (remain == plen));

  a_r8_remain_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (remain[1:0] == 2'b00 && remain != 32'd0 && remain <= plen));

  a_r12_src_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> $stable(src));
endmodule

bind cyc_audio_dma cad_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(eng_en), .paused(eng_paused), .done_evt(done_evt),
  .irq(irq), .remain(remain), .plen(plen_q), .src(src_q), .wrap(wrap),
  .mem_req(mem_req), .tx_valid(tx_valid), .rx_ready(rx_ready)
);

// File: tb/cyc_audio_dma_bench.sv
module cyc_audio_dma_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 3;
  localparam int LVL_W = 6;
  localparam logic [31:0] RD_PAT = 32'h5A5A_0000;
  localparam logic [31:0] RX_PAT = 32'hD000_0000;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, mem_req, mem_we, mem_gnt, tx_valid, tx_ready, rx_valid, rx_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, tx_data, rx_data;
  logic [LVL_W-1:0] tx_room = 16, rx_level = 16;
  logic stall_mode = 0, rx_en = 0;
  logic [31:0] rx_seq = 0;
  int cyc = 0;

  int checks = 0, failures = 0;
  int nt = 0, nw = 0, nreq = 0, seq_err = 0, irq_rise = 0;
  logic irq_prev = 0;
  logic [31:0] exp_base = 0;
  int ring_words = 1;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cyc_audio_dma #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_cyc_audio_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_room(tx_room), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .rx_level(rx_level)
  );

  // memory and device models
  assign mem_gnt   = mem_req && (!stall_mode || cyc[0]);
  assign mem_rdata = mem_addr ^ RD_PAT;
  assign tx_ready  = 1'b1;
  assign rx_valid  = rx_en;
  assign rx_data   = RX_PAT + rx_seq;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rx_valid && rx_ready) rx_seq <= rx_seq + 1;
  end

  // monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (mem_req) nreq++;
    if (mem_req && mem_gnt && mem_we) begin
      if (mem_addr != exp_base + 32'(4 * (nw % ring_words)) || mem_wdata != RX_PAT + 32'(nw)) begin
        seq_err++;
        $display("write mismatch #%0d addr=%h data=%h", nw, mem_addr, mem_wdata);
      end
      nw++;
    end
    if (tx_valid && tx_ready) begin
      if (tx_data != ((exp_base + 32'(4 * (nt % ring_words))) ^ RD_PAT)) begin
        seq_err++;
        $display("send mismatch #%0d data=%h", nt, tx_data);
      end
      nt++;
    end
    if (irq && !irq_prev) irq_rise++;
    irq_prev = irq;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_words(input bit tx_side, input int target);
    for (int i = 0; i < 3000; i++) begin
      if ((tx_side ? nt : nw) >= target) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_status(input logic [31:0] mask, input logic [31:0] val);
    logic [31:0] s;
    for (int i = 0; i < 300; i++) begin
      rd_reg(8'h0C, s);
      if ((s & mask) == val) break;
    end
  endtask

  task automatic clear_counts(input logic [31:0] base, input int words);
    exp_base = base; ring_words = words;
    nt = 0; nw = 0; nreq = 0; seq_err = 0; rx_seq = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd_reg(8'h0C, d); check("R1 reset status", d, 0);
    rd_reg(8'h30, d); check("R1 reset remain", d, 0);
    check("R1 reset irq", {31'b0, irq}, 0);
    check("R1 reset handshakes", {29'b0, mem_req, tx_valid, rx_ready}, 0);
  endtask

  task automatic t_refused;
    logic [31:0] d;
    wr_reg(8'h44, 32'd8);
    wr_reg(8'h24, 32'h0000_0202);
    wr_reg(8'h00, 1);
    rd_reg(8'h00, d); check("R2 bad direction cmd", d, 0);
    rd_reg(8'h0C, d); check("R2 bad direction status", d, 0);
    wr_reg(8'h24, 32'h0000_4202);
    wr_reg(8'h44, 32'hC000_0002);
    rd_reg(8'h44, d); check("R8 length mask", d, 0);
    wr_reg(8'h00, 1);
    rd_reg(8'h00, d); check("R2 zero length cmd", d, 0);
  endtask

  task automatic t_send;
    logic [31:0] d;
    int snap, snap_req;
    // 3 periods of 3 words, burst 2
    wr_reg(8'h34, 32'h0000_1000);
    wr_reg(8'h44, 32'd12);
    wr_reg(8'h28, (32'd2 << 28) | (32'd1 << 20));
    wr_reg(8'h24, 32'h0000_4202);
    tx_room = 16;
    clear_counts(32'h1000, 9);
    wr_reg(8'h00, 1);
    rd_reg(8'h0C, d); check("R1 enabled after start", d & 1, 1);
    wait_words(1, 31);
    check("R3 R5 send order and ring wrap", seq_err, 0);
    check("R7 irq set after period", {31'b0, irq}, 1);
    wr_reg(8'h34, 32'h0000_7000);
    wr_reg(8'h24, 32'h0000_4203);
    wait_status(2, 2);
    rd_reg(8'h0C, d); check("R10 paused status", d, 3);
    snap = nt; snap_req = nreq;
    repeat (20) @(negedge clk);
    check("R10 no words while paused", nt, snap);
    check("R10 no requests while paused", nreq, snap_req);
    rd_reg(8'h30, d); check("R8 remaining bytes", d, 32'(12 - 4 * (nt % 3)));
    rd_reg(8'h54, d); check("R9 period count modulo", d, 32'((nt / 3) % 8));
    wr_reg(8'h1C, 1);
    check("R7 irq cleared", {31'b0, irq}, 0);
    wr_reg(8'h24, 32'h0000_4202);
    wait_words(1, snap + 5);
    check("R10 resume continues sequence", seq_err, 0);
    check("R10 resume moved on", (nt >= snap + 5) ? 1 : 0, 1);
    wr_reg(8'h00, 0);
    wait_status(1, 0);
    rd_reg(8'h0C, d); check("R11 stopped status", d, 0);
    check("R11 stop at burst boundary", ((nt % 3) != 1) ? 1 : 0, 1);
    snap = nt;
    repeat (10) @(negedge clk);
    check("R11 no words after stop", nt, snap);
    rd_reg(8'h34, d); check("R12 source write ignored while enabled", d, 32'h1000);
  endtask

  task automatic t_flow_send;
    logic [31:0] d;
    wr_reg(8'h28, 32'd3 << 20);
    wr_reg(8'h44, 32'd16);
    tx_room = 3;
    clear_counts(32'h1000, 4);
    wr_reg(8'h00, 1);
    repeat (30) @(negedge clk);
    check("R6 send held for room", nreq, 0);
    tx_room = 4;
    wait_words(1, 8);
    check("R6 send flows with room", (nt >= 8 && seq_err == 0) ? 1 : 0, 1);
    wr_reg(8'h00, 0);
    wait_status(1, 0);
    rd_reg(8'h0C, d); check("R11 stopped after flow test", d, 0);
  endtask

  task automatic t_receive;
    logic [31:0] d;
    // 2 periods of 3 words, burst 4 truncated by period end
    wr_reg(8'h3C, 32'h0000_2000);
    wr_reg(8'h44, 32'd12);
    wr_reg(8'h28, (32'd1 << 24) | (32'd3 << 20));
    wr_reg(8'h24, 32'h0000_2202);
    rx_level = 3; rx_en = 1; stall_mode = 1;
    clear_counts(32'h2000, 6);
    wr_reg(8'h00, 1);
    repeat (30) @(negedge clk);
    check("R6 receive held for level", nw + nreq, 0);
    rx_level = 16;
    wait_words(0, 15);
    check("R4 R5 receive order and ring wrap", seq_err, 0);
    check("R4 receive progressed", (nw >= 15) ? 1 : 0, 1);
    wr_reg(8'h00, 0);
    wait_status(1, 0);
    rx_en = 0; stall_mode = 0;
    rd_reg(8'h54, d); check("R9 receive period count", d, 32'((nw / 3) % 8));
  endtask

  task automatic t_collide;
    logic [31:0] d;
    wr_reg(8'h34, 32'h0000_3000);
    wr_reg(8'h44, 32'd4);
    wr_reg(8'h28, 32'd0);
    wr_reg(8'h24, 32'h0000_4202);
    wr_reg(8'h1C, 1);
    clear_counts(32'h3000, 1);
    irq_rise = 0;
    wr_reg(8'h00, 1);
    reg_wr = 1; reg_addr = 8'h1C; reg_wdata = 1;
    wait_words(1, 12);
    reg_addr = 8'h00; reg_wdata = 0;
    @(negedge clk);
    reg_addr = 8'h1C; reg_wdata = 1;
    repeat (10) @(negedge clk);
    reg_wr = 0;
    @(negedge clk);
    check("R7 one irq rise per period under constant clear", irq_rise, nt);
    check("R7 irq low after clears", {31'b0, irq}, 0);
    rd_reg(8'h54, d); check("R9 count equals periods", d, 32'(nt % 8));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_refused();
    t_send();
    t_flow_send();
    t_receive();
    t_collide();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule